// File: doc/BRIEF.md
# Sixteen-Bit Frame to Byte-Pair Serial Bridge

This block takes in an asynchronous serial frame with a sixteen-bit payload. That frame is too wide for an ordinary PC terminal to decode. The block hands the payload on as two standard eight-bit characters that a common serial port accepts.

The input frame has these fields:
- one low start bit;
- sixteen data bits, least significant bit first;
- an even-parity bit;
- one high stop bit.

The receive line is synchronized, and a falling edge is confirmed at half a bit time. Each field is then sampled at the centre of its bit. A frame with bad parity or a low stop bit is thrown away and raises a sticky error flag. A good word is held in a one-word register. The output path sends the high byte first. The low byte follows once the transmitter is idle again.

Both links run at the same rate. That rate is set in clock cycles per bit. The default of 2604 is 19200 baud from a 50 MHz clock. If a word completes while the previous pair is still leaving, the new word is dropped and an overrun flag is latched.

Top module: `wide_frame_bridge`

## Requirements
- R1: After reset, tx_o is high and frame_err_o and overrun_o are low.
- R2: An input frame carries its fields in this order: start bit (low), sixteen data bits (least significant first), an even-parity bit, and a stop bit (high). Even parity means the data bits and the parity bit together hold an even number of ones. A good frame yields exactly two output characters: bits 15..8 first, then bits 7..0.
- R3: Each output character has these fields in order:
  - one low start bit;
  - eight data bits, least significant first;
  - when OUT_PAR_EN=1 (the default), a bit that makes the count of ones in the data and this bit even;
  - OUT_STOP_BITS high stop bits (default 1).
  The line rests high between characters.
- R4: A low pulse on rx_i shorter than half a bit time is not taken as a start. It produces no output and sets no flag.
- R5: A frame whose data and parity bit together hold an odd number of ones produces no output and sets frame_err_o.
- R6: A frame whose stop bit samples low produces no output and sets frame_err_o.
- R7: The second character of a pair starts only after every stop bit of the first has been sent. Characters never overlap.
- R8: A good frame that completes while a pair is still being sent is dropped and sets overrun_o. The pair in progress is sent unchanged.
- R9: frame_err_o and overrun_o stay high until reset. Later good frames are still converted.
- R10: Every input and output bit lasts CLKS_PER_BIT clock cycles. Input bits are sampled at their centres.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Wide-frame serial input, idle high |
| tx_o | output | 1 | Byte-character serial output, idle high |
| frame_err_o | output | 1 | Sticky parity or stop-bit error |
| overrun_o | output | 1 | Sticky dropped-word indication |

## Verification
The assertions assume several things about the input:
- rx_i rests high between frames;
- each bit is held for the full bit time;
- the far end uses the same bit period;
- reset is applied only while both lines are idle.

The stimulus keeps within these limits as follows:
- It drives every bit for exactly CLKS_PER_BIT cycles, away from the sampling clock edge.
- It inserts a long idle gap after each random frame, except where it deliberately crowds two frames together to force an overrun.
- It reasserts reset only after the output has fallen quiet.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP
  } rx_state_e;

  typedef enum logic [1:0] {
    SEQ_IDLE, SEQ_HI, SEQ_LO, SEQ_END
  } seq_state_e;
endpackage

// File: rtl/wide_rx.sv
module wide_rx
  import bridge_pkg::*;
#(
  parameter int unsigned CLKS_PER_BIT = 2604,
  parameter int unsigned DW           = WORD_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_i,
  output logic          done_o,
  output logic          bad_o,
  output logic [DW-1:0] word_o
);
  localparam int unsigned CW = $clog2(CLKS_PER_BIT);
  localparam int unsigned IW = $clog2(DW);
  localparam logic [CW-1:0] CNT_MAX  = CW'(CLKS_PER_BIT - 1);
  localparam logic [CW-1:0] HALF_M1  = CW'(CLKS_PER_BIT / 2 - 1);
  localparam logic [IW-1:0] IDX_LAST = IW'(DW - 1);

  logic          s1_q, s2_q, prev_q, par_q;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] idx_q;
  logic [DW-1:0] sh_q;
  rx_state_e     st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
      par_q  <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      st_q   <= RX_IDLE;
      done_o <= 1'b0;
      bad_o  <= 1'b0;
      word_o <= '0;
    end else begin
      s1_q   <= rx_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      done_o <= 1'b0;
      unique case (st_q)
        RX_IDLE: if (prev_q && !s2_q) begin  // falling edge only
          st_q  <= RX_START;
          cnt_q <= '0;
        end
        RX_START: if (cnt_q == HALF_M1) begin
          cnt_q <= '0;
          idx_q <= '0;
          st_q  <= s2_q ? RX_IDLE : RX_DATA;
        end else cnt_q <= cnt_q + 1'b1;
        RX_DATA: if (cnt_q == CNT_MAX) begin
          cnt_q <= '0;
          sh_q  <= {s2_q, sh_q[DW-1:1]};
          if (idx_q == IDX_LAST) st_q <= RX_PAR;
          else idx_q <= idx_q + 1'b1;
        end else cnt_q <= cnt_q + 1'b1;
        RX_PAR: if (cnt_q == CNT_MAX) begin
          cnt_q <= '0;
          par_q <= s2_q;
          st_q  <= RX_STOP;
        end else cnt_q <= cnt_q + 1'b1;
        RX_STOP: if (cnt_q == CNT_MAX) begin
          cnt_q  <= '0;
          done_o <= 1'b1;
          word_o <= sh_q;
          bad_o  <= (^sh_q ^ par_q) | ~s2_q;
          st_q   <= RX_IDLE;
        end else cnt_q <= cnt_q + 1'b1;
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  assert_done_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/byte_tx.sv
module byte_tx
  import bridge_pkg::*;
#(
  parameter int unsigned CLKS_PER_BIT = 2604,
  parameter int unsigned PAR_EN       = 1,
  parameter int unsigned STOP_BITS    = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              ready_o,
  output logic              tx_o
);
  localparam int unsigned LEN = 1 + BYTE_W + PAR_EN + STOP_BITS;
  localparam int unsigned CW  = $clog2(CLKS_PER_BIT);
  localparam int unsigned BW  = $clog2(LEN);
  localparam logic [CW-1:0] CNT_MAX  = CW'(CLKS_PER_BIT - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(LEN - 1);

  logic [LEN-1:0] load_w, sh_q;
  logic [CW-1:0]  cnt_q;
  logic [BW-1:0]  nbit_q;
  logic           busy_q;

  generate
    if (PAR_EN != 0) begin : g_par
      always_comb load_w = {{STOP_BITS{1'b1}}, ^data_i, data_i, 1'b0};
    end else begin : g_nopar
      always_comb load_w = {{STOP_BITS{1'b1}}, data_i, 1'b0};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      nbit_q <= '0;
      busy_q <= 1'b0;
    end else if (start_i && !busy_q) begin
      sh_q   <= load_w;
      cnt_q  <= '0;
      nbit_q <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == CNT_MAX) begin
        cnt_q <= '0;
        sh_q  <= {1'b1, sh_q[LEN-1:1]};
        if (nbit_q == BIT_LAST) busy_q <= 1'b0;
        else nbit_q <= nbit_q + 1'b1;
      end else cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ready_o = !busy_q;
  assign tx_o    = sh_q[0];

  assert_idle_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> tx_o);
endmodule

// File: rtl/wide_frame_bridge.sv
module wide_frame_bridge
  import bridge_pkg::*;
#(
  parameter int unsigned CLKS_PER_BIT  = 2604,
  parameter int unsigned OUT_PAR_EN    = 1,
  parameter int unsigned OUT_STOP_BITS = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic tx_o,
  output logic frame_err_o,
  output logic overrun_o
);
  logic              rx_done, rx_bad, tx_start, tx_ready;
  logic [WORD_W-1:0] rx_word, hold_q;
  logic [BYTE_W-1:0] tx_data;
  seq_state_e        st_q;

  wide_rx #(.CLKS_PER_BIT(CLKS_PER_BIT), .DW(WORD_W)) rx_i0 (
    .clk_i, .rst_ni, .rx_i,
    .done_o(rx_done), .bad_o(rx_bad), .word_o(rx_word)
  );

  byte_tx #(.CLKS_PER_BIT(CLKS_PER_BIT), .PAR_EN(OUT_PAR_EN),
            .STOP_BITS(OUT_STOP_BITS)) tx_i0 (
    .clk_i, .rst_ni, .start_i(tx_start), .data_i(tx_data),
    .ready_o(tx_ready), .tx_o
  );

  always_comb begin
    tx_start = ((st_q == SEQ_HI) || (st_q == SEQ_LO)) && tx_ready;
    tx_data  = (st_q == SEQ_HI) ? hold_q[WORD_W-1:BYTE_W] : hold_q[BYTE_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= SEQ_IDLE;
      hold_q      <= '0;
      frame_err_o <= 1'b0;
      overrun_o   <= 1'b0;
    end else begin
      if (rx_done && rx_bad) frame_err_o <= 1'b1;
      unique case (st_q)
        SEQ_IDLE: if (rx_done && !rx_bad) begin
          hold_q <= rx_word;
          st_q   <= SEQ_HI;
        end
        SEQ_HI:  if (tx_ready) st_q <= SEQ_LO;
        SEQ_LO:  if (tx_ready) st_q <= SEQ_END;
        SEQ_END: if (tx_ready) st_q <= SEQ_IDLE;
        default: st_q <= SEQ_IDLE;
      endcase
      if (rx_done && !rx_bad && st_q != SEQ_IDLE) overrun_o <= 1'b1;
    end
  end

  assert_launch_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start |=> !tx_ready);
  assert_hold_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != SEQ_IDLE && $past(st_q) != SEQ_IDLE) |-> $stable(hold_q));
  assert_overrun_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> $past(rx_done && !rx_bad && st_q != SEQ_IDLE));
  assert_bad_no_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done && rx_bad && st_q == SEQ_IDLE) |=> st_q == SEQ_IDLE);
  assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |=> frame_err_o);
  assert_ovr_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);
endmodule

// File: tb/wide_frame_bridge_tb.sv
module wide_frame_bridge_tb_top;
  localparam int CPB = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1;
  logic tx, ferr, ovr;
  int   n_chk = 0, n_bad = 0;
  logic [7:0] got_q[$];
  logic [7:0] exp_q[$];

  always #2.5 clk = ~clk;

  wide_frame_bridge #(.CLKS_PER_BIT(CPB)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx),
    .tx_o(tx), .frame_err_o(ferr), .overrun_o(ovr)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  function automatic logic odd_fix(input logic [15:0] w);
    return ^w;  // even parity bit for the word
  endfunction

  task automatic send_bit(input logic b);
    rx = b;
    repeat (CPB) @(negedge clk);
  endtask

  task automatic send_frame(input logic [15:0] w, input bit flip_par, input logic stop);
    send_bit(1'b0);
    for (int i = 0; i < 16; i++) send_bit(w[i]);
    send_bit(odd_fix(w) ^ flip_par);
    send_bit(stop);
    rx = 1'b1;
  endtask

  task automatic idle_bits(input int n);
    rx = 1'b1;
    repeat (n * CPB) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic compare_out(input string req);
    check(got_q.size() == exp_q.size(), req, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      check(got_q[i] == exp_q[i], req, got_q[i], exp_q[i]);
    got_q.delete();
    exp_q.delete();
  endtask

  // Independent decoder for output characters (R3, R7, R10)
  initial begin
    logic [7:0] b;
    logic p, s;
    forever begin
      @(negedge clk);
      if (rst_n && tx == 1'b0) begin
        repeat (CPB / 2 - 1) @(negedge clk);
        check(tx == 1'b0, "R3 start", tx, 0);
        for (int i = 0; i < 8; i++) begin
          repeat (CPB) @(negedge clk);
          b[i] = tx;
        end
        repeat (CPB) @(negedge clk);
        p = tx;
        repeat (CPB) @(negedge clk);
        s = tx;
        check(p == ^b, "R3 parity", p, ^b);
        check(s == 1'b1, "R7 R10 stop", s, 1);
        got_q.push_back(b);
      end
    end
  end

  initial begin
    #(150000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] w;
    logic [15:0] dir[4] = '{16'h0000, 16'hFFFF, 16'h8001, 16'h4563};
    void'($urandom(32'd1234));
    do_reset();
    check(tx == 1'b1, "R1 tx idle", tx, 1);
    check(ferr == 1'b0, "R1 frame_err", ferr, 0);
    check(ovr == 1'b0, "R1 overrun", ovr, 0);

    // R2: directed then random words, high byte first
    for (int k = 0; k < 24; k++) begin
      w = (k < 4) ? dir[k] : 16'($urandom);
      send_frame(w, 1'b0, 1'b1);
      exp_q.push_back(w[15:8]);
      exp_q.push_back(w[7:0]);
      idle_bits(26);
    end
    compare_out("R2 byte order");
    check(ferr == 1'b0 && ovr == 1'b0, "R2 no flags", {ferr, ovr}, 0);

    // R4: short glitch
    rx = 1'b0;
    repeat (CPB / 4) @(negedge clk);
    idle_bits(30);
    compare_out("R4 glitch output");
    check(ferr == 1'b0, "R4 glitch flag", ferr, 0);

    // R5: bad parity
    send_frame(16'hA5C3, 1'b1, 1'b1);
    idle_bits(30);
    compare_out("R5 dropped");
    check(ferr == 1'b1, "R5 frame_err", ferr, 1);
    do_reset();

    // R6: low stop bit, then R9 good frame still passes with flag held
    send_frame(16'h1234, 1'b0, 1'b0);
    idle_bits(30);
    compare_out("R6 dropped");
    check(ferr == 1'b1, "R6 frame_err", ferr, 1);
    send_frame(16'hBEEF, 1'b0, 1'b1);
    exp_q.push_back(8'hBE);
    exp_q.push_back(8'hEF);
    idle_bits(30);
    compare_out("R9 after error");
    check(ferr == 1'b1, "R9 frame_err held", ferr, 1);
    do_reset();

    // R8: second frame lands while first pair is leaving
    send_frame(16'hC0DE, 1'b0, 1'b1);
    idle_bits(1);
    send_frame(16'h7711, 1'b0, 1'b1);
    exp_q.push_back(8'hC0);
    exp_q.push_back(8'hDE);
    idle_bits(30);
    compare_out("R8 overrun drop");
    check(ovr == 1'b1, "R8 overrun flag", ovr, 1);
    check(ferr == 1'b0, "R8 no frame_err", ferr, 0);
    send_frame(16'h0F5A, 1'b0, 1'b1);
    exp_q.push_back(8'h0F);
    exp_q.push_back(8'h5A);
    idle_bits(30);
    compare_out("R9 after overrun");
    check(ovr == 1'b1, "R9 overrun held", ovr, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule